// File: doc/BRIEF.md
# External Interrupt Edge-Detect Controller

This block watches four asynchronous external interrupt request pins. Each pin first passes through a two-stage synchronizer. The block then looks for one kind of transition on it, rising or falling, as chosen by a per-pin select bit. When the chosen transition appears, the block latches a pending flag for that pin. The flags are masked by per-pin enable bits and ORed together into a single interrupt line to the processor.

Software reaches the configuration and status through a byte-wide register port. The port has eight consecutive byte addresses starting at 0xFFF2, and reads are combinational. A pending flag can only be cleared by software, by writing 0 to it. Writing 1 to a flag bit leaves it unchanged. The upper nibble of the edge-select register is hardwired.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After reset the eight registers read, in address order 0xFFF2 through 0xFFF9: 0x70, 0x00, 0x10, 0x00, 0x00, 0x10, 0x00, 0x00.
- R2: Pin n uses bit n of the edge-select register at 0xFFF2. When that bit is 0, a high-to-low transition on pin n sets flag n (bit n at 0xFFF7) and a low-to-high transition does not.
- R3: When edge-select bit n is 1, a low-to-high transition on pin n sets flag n and a high-to-low transition does not.
- R4: At 0xFFF2, bit 7 always reads 0 and bits 6..4 always read 1, whatever value is written.
- R5: A write to 0xFFF7 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. No flag is ever set by a write.
- R6: If a detected edge and a clearing write hit the same flag in the same clock, the flag ends up set.
- R7: The interrupt output is 1 exactly when some flag n is set while enable bit n (bit n of 0xFFF4) is 1.
- R8: Changing an edge-select bit while the pin is held steady does not set a flag.
- R9: Reads of addresses outside 0xFFF2..0xFFF9 return 0x00, and writes to those addresses change no register.
- R10: A pin change made between two clock edges shows up in its flag after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqPin | input | 4 | External interrupt pins, asynchronous |
| busAddr | input | 16 | Register byte address |
| busWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The assertions check four things on every cycle:
- the hardwired upper nibble of the edge-select register;
- the zero read-back outside the register window;
- that no flag ever drops unless a request-register write happened in the previous cycle;
- that at most one write strobe leaves the decoder, and that the interrupt line only rises after a new flag or an enable write.

Only the bench scenarios can show that the correct polarity is detected for each select value. The same holds for the exact three-edge latency, for an edge winning over a simultaneous clear, and for select changes on a steady pin producing no request.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;
  localparam int NumPins = 4;
  localparam int AddrW = 16;
  localparam int DataW = 8;
  localparam int NumRegs = 8;
  localparam logic [AddrW-1:0] RegBase = 16'hFFF2;

  // register order matters: it is the address order from RegBase
  typedef enum logic [2:0] {
    SelEdge1 = 3'd0,
    SelEdge2 = 3'd1,
    SelEn1   = 3'd2,
    SelEn2   = 3'd3,
    SelEn3   = 3'd4,
    SelReq1  = 3'd5,
    SelReq2  = 3'd6,
    SelReq3  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrEdge1;
    logic    wrEdge2;
    logic    wrEn1;
    logic    wrEn2;
    logic    wrEn3;
    logic    wrReq1;
    logic    rdHit;
    regSel_e rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_edge_decode.sv
module irq_edge_decode
  import irq_edge_pkg::*;
#(
  parameter int AW = AddrW,
  parameter logic [AW-1:0] Base = RegBase,
  parameter int Regs = NumRegs
) (
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  output ctrlStrobes_t  strobes
);
  localparam int SelW = $clog2(Regs);

  logic [AW-1:0] offset;
  logic          inRange;
  regSel_e       sel;

  always_comb begin
    offset  = busAddr - Base;
    inRange = (busAddr >= Base) && (offset < AW'(Regs));
    sel     = regSel_e'(offset[SelW-1:0]);
  end

  always_comb begin
    strobes         = '0;
    strobes.rdHit   = inRange;
    strobes.rdSel   = sel;
    if (inRange && busWrEn) begin
      unique case (sel)
        SelEdge1: strobes.wrEdge1 = 1'b1;
        SelEdge2: strobes.wrEdge2 = 1'b1;
        SelEn1:   strobes.wrEn1   = 1'b1;
        SelEn2:   strobes.wrEn2   = 1'b1;
        SelEn3:   strobes.wrEn3   = 1'b1;
        SelReq1:  strobes.wrReq1  = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/irq_edge_datapath.sv
module irq_edge_datapath
  import irq_edge_pkg::*;
#(
  parameter int Pins = NumPins,
  parameter int DW = DataW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [Pins-1:0] irqPin,
  input  ctrlStrobes_t    strobes,
  input  logic [DW-1:0]   busWrData,
  output logic [DW-1:0]   busRdData,
  output logic [Pins-1:0] flagVec,
  output logic [Pins-1:0] enLow,
  output logic            irqOut
);
  localparam logic [DW-1:0] PinMask    = DW'((1 << Pins) - 1);
  localparam logic [DW-1:0] Edge1Fixed = DW'(8'h70);
  localparam logic [DW-1:0] En1Reset   = DW'(8'h10);
  localparam logic [DW-1:0] Req1Reset  = DW'(8'h10);

  logic [Pins-1:0] syncA, syncB, syncPrev, edgeHit;
  logic [Pins-1:0] edgeSel;
  logic [DW-1:0]   edge2Reg, en1Reg, en2Reg, en3Reg, req1Reg;

  for (genvar p = 0; p < Pins; p++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[p]    <= 1'b0;
        syncB[p]    <= 1'b0;
        syncPrev[p] <= 1'b0;
      end else begin
        syncA[p]    <= irqPin[p];
        syncB[p]    <= syncA[p];
        syncPrev[p] <= syncB[p];
      end
    end
    // only real transitions of the synchronized pin count
    assign edgeHit[p] = edgeSel[p] ? (syncB[p] & ~syncPrev[p])
                                   : (~syncB[p] & syncPrev[p]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeSel  <= '0;
      edge2Reg <= '0;
      en1Reg   <= En1Reset;
      en2Reg   <= '0;
      en3Reg   <= '0;
    end else begin
      if (strobes.wrEdge1) edgeSel  <= busWrData[Pins-1:0];
      if (strobes.wrEdge2) edge2Reg <= busWrData;
      if (strobes.wrEn1)   en1Reg   <= busWrData;
      if (strobes.wrEn2)   en2Reg   <= busWrData;
      if (strobes.wrEn3)   en3Reg   <= busWrData;
    end
  end

  logic [DW-1:0] clrMask, setMask;
  always_comb begin
    clrMask = strobes.wrReq1 ? ~busWrData : '0;
    setMask = DW'(edgeHit) & PinMask;
  end

  // a set in the same cycle overrides a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) req1Reg <= Req1Reset;
    else       req1Reg <= (req1Reg & ~clrMask) | setMask;
  end

  always_comb begin
    flagVec = req1Reg[Pins-1:0];
    enLow   = en1Reg[Pins-1:0];
    irqOut  = |(flagVec & enLow);
  end

  always_comb begin
    busRdData = '0;
    if (strobes.rdHit) begin
      unique case (strobes.rdSel)
        SelEdge1: busRdData = (Edge1Fixed & ~PinMask) | DW'(edgeSel);
        SelEdge2: busRdData = edge2Reg;
        SelEn1:   busRdData = en1Reg;
        SelEn2:   busRdData = en2Reg;
        SelEn3:   busRdData = en3Reg;
        SelReq1:  busRdData = req1Reg;
        default:  busRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
  import irq_edge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  irqPin,
  input  logic [15:0] busAddr,
  input  logic        busWrEn,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  output logic        irqOut
);
  ctrlStrobes_t         strobes;
  logic [NumPins-1:0]   flagVec;
  logic [NumPins-1:0]   enLow;

  irq_edge_decode #(.AW(AddrW), .Base(RegBase), .Regs(NumRegs)) u_decode (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes)
  );

  irq_edge_datapath #(.Pins(NumPins), .DW(DataW)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .irqPin    (irqPin),
    .strobes   (strobes),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .flagVec   (flagVec),
    .enLow     (enLow),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/irq_edge_chk.sv
module irq_edge_chk
  import irq_edge_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [15:0]        busAddr,
  input logic [7:0]         busRdData,
  input logic               irqOut,
  input ctrlStrobes_t       strobes,
  input logic [NumPins-1:0] flagVec
);
  // R4
  edge_hi_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 16'hFFF2) |-> (busRdData[7:4] == 4'h7));

  // R9
  out_range_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < 16'hFFF2 || busAddr > 16'hFFF9) |-> (busRdData == 8'h00));

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.wrReq1) |-> ((flagVec & $past(flagVec)) == $past(flagVec)));

  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrEdge1, strobes.wrEdge2, strobes.wrEn1,
              strobes.wrEn2, strobes.wrEn3, strobes.wrReq1}));

  // R7
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(strobes.wrEn1) || ((flagVec & ~$past(flagVec)) != '0)));
endmodule

bind irq_edge_ctrl irq_edge_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busRdData (busRdData),
  .irqOut    (irqOut),
  .strobes   (strobes),
  .flagVec   (flagVec)
);

// File: tb/irq_edge_ctrl_tb.sv
module irq_edge_ctrl_tb;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  irqPin = 4'h0;
  logic [15:0] busAddr = 16'h0000;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = 8'h00;
  logic [7:0]  busRdData;
  logic        irqOut;

  int tests = 0;
  int fails = 0;

  logic [3:0] expFlags = 4'h0;
  logic [3:0] expSel   = 4'h0;
  logic [3:0] expEn    = 4'h0;

  always #(ClkPeriod/2) clk = ~clk;

  irq_edge_ctrl u_dut (
    .clk(clk), .rstN(rstN), .irqPin(irqPin), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  function automatic logic [3:0] edgesFor(logic [3:0] oldLvl, logic [3:0] newLvl, logic [3:0] sel);
    return (sel & ~oldLvl & newLvl) | (~sel & oldLvl & ~newLvl);
  endfunction

  function automatic logic expIrq(logic [3:0] f, logic [3:0] e);
    return |(f & e);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic setPins(logic [3:0] v);
    logic [3:0] e;
    e = edgesFor(irqPin, v, expSel);
    @(negedge clk);
    irqPin = v;
    repeat (4) @(negedge clk);
    expFlags |= e;
  endtask

  task automatic finish();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    logic [7:0] d;
    logic [7:0] rstVals [8];
    rstVals = '{8'h70, 8'h00, 8'h10, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    for (int i = 0; i < 8; i++) begin
      rd(16'hFFF2 + 16'(i), d);
      check("R1", d, rstVals[i]);
    end
    check("R1 irq", irqOut, 1'b0);

    // R4 hardwired upper nibble
    wr(16'hFFF2, 8'h80);
    rd(16'hFFF2, d);
    check("R4", d, 8'h70);
    wr(16'hFFF2, 8'h00);

    // R9 outside window
    rd(16'hFFF1, d); check("R9 low", d, 8'h00);
    rd(16'hFFFA, d); check("R9 high", d, 8'h00);
    wr(16'hFFFA, 8'hFF);
    wr(16'hFFF1, 8'hFF);
    rd(16'hFFF4, d); check("R9 no write", d, 8'h10);

    // R2 falling select: rising ignored, falling sets
    setPins(4'h1);
    rd(16'hFFF7, d); check("R2 rise ignored", d[3:0], 4'h0);
    setPins(4'h0);
    rd(16'hFFF7, d); check("R2 fall sets", d[3:0], 4'h1);

    // R5 write 1 keeps, write 0 clears (upper bit4 kept at 1)
    wr(16'hFFF7, 8'hFF);
    rd(16'hFFF7, d); check("R5 write1 keeps", d, 8'h11);
    wr(16'hFFF7, 8'hF0);
    expFlags = 4'h0;
    rd(16'hFFF7, d); check("R5 write0 clears", d, 8'h10);

    // R8 select change on steady pins: pins 0b0101
    setPins(4'h5);
    wr(16'hFFF7, 8'hF0); expFlags = 4'h0;
    wr(16'hFFF2, 8'h0F); expSel = 4'hF;
    repeat (4) @(negedge clk);
    rd(16'hFFF7, d); check("R8 sel up", d[3:0], 4'h0);
    wr(16'hFFF2, 8'h00); expSel = 4'h0;
    repeat (4) @(negedge clk);
    rd(16'hFFF7, d); check("R8 sel down", d[3:0], 4'h0);

    // R3 rising select on pin 3
    wr(16'hFFF2, 8'h08); expSel = 4'h8;
    setPins(4'hD);
    rd(16'hFFF7, d); check("R3 rise sets", d[3:0], 4'h8);
    setPins(4'h5);
    rd(16'hFFF7, d); check("R3 fall ignored", d[3:0], 4'h8);

    // R7 enable gating
    rd(16'hFFF7, d);
    check("R7 disabled", irqOut, 1'b0);
    wr(16'hFFF4, 8'h18); expEn = 4'h8;
    #1 check("R7 enabled", irqOut, 1'b1);
    wr(16'hFFF4, 8'h17); expEn = 4'h7;
    #1 check("R7 other enables", irqOut, 1'b0);
    wr(16'hFFF7, 8'hF0); expFlags = 4'h0;

    // R10 latency: pin 1 falls (select 0)
    busAddr = 16'hFFF7;
    @(negedge clk); irqPin = 4'h7;
    repeat (4) @(negedge clk);
    @(negedge clk); irqPin = 4'h5;
    @(negedge clk); #1 check("R10 edge1", busRdData[1], 1'b0);
    @(negedge clk); #1 check("R10 edge2", busRdData[1], 1'b0);
    @(negedge clk); #1 check("R10 edge3", busRdData[1], 1'b1);
    expFlags = 4'h2;

    // R6 edge and clear in the same cycle on pin 1
    setPins(4'h7);
    @(negedge clk); irqPin = 4'h5;
    @(negedge clk);
    wr(16'hFFF7, 8'hF0);
    rd(16'hFFF7, d); check("R6 edge wins", d[3:0], 4'h2);
    wr(16'hFFF7, 8'hF0); expFlags = 4'h0;

    // random mix: R2 R3 R5 R7
    for (int it = 0; it < 60; it++) begin
      int op;
      op = $urandom_range(0, 5);
      if (op == 0) begin
        logic [3:0] s;
        s = 4'($urandom);
        wr(16'hFFF2, {4'h0, s}); expSel = s;
      end else if (op == 1) begin
        logic [3:0] e;
        e = 4'($urandom);
        wr(16'hFFF4, {4'h1, e}); expEn = e;
      end else if (op == 2) begin
        logic [3:0] c;
        c = 4'($urandom);
        wr(16'hFFF7, {4'hF, c}); expFlags &= c;
      end else begin
        setPins(4'($urandom));
      end
      rd(16'hFFF7, d);
      check("R2/R3/R5 random flags", d[3:0], expFlags);
      check("R7 random irq", irqOut, expIrq(expFlags, expEn));
    end

    finish();
  end
endmodule